// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is an 8-bit integer arithmetic and logic unit that produces a result together with a six-bit condition word. The caller presents two operands, an operation code and the current condition word, and raises `issue` for one cycle. On the next rising clock edge the unit captures the new result and the new condition word. It also raises a writeback strobe whenever the operation produces a value that should be stored. Each operation changes only the condition bits that belong to it. Any bit it does not own is copied from `flags_in`.

A small three-state controller sequences the outputs. `S_IDLE` is the resting state. `S_WRITE` holds for the one cycle after an issued operation that writes a result, and `wb_valid` is high only in this state. `S_PROBE` holds for the one cycle after a compare or test, which update the condition word but write nothing. The transitions are as follows. On `issue` of a writing operation the controller goes to `S_WRITE`. On `issue` of a compare or test it goes to `S_PROBE`. On `issue` of an unused code, or on no `issue`, it goes to `S_IDLE`. Both `S_WRITE` and `S_PROBE` also return to `S_IDLE` or re-enter by the same rules on the following cycle.

Top module: `flag_alu`

## Requirements
- R1: The condition word packs carry at bit 0, parity at bit 1, half-carry at bit 2, zero at bit 3, sign at bit 4 and overflow at bit 5. While `rst_n` is low, `result`, `wb_valid` and `flags_out` are all zero.
- R2: Outputs are registered. The values for an operation issued before a rising edge appear after that edge. `wb_valid` is a one-cycle pulse. Without `issue`, `result` and `flags_out` hold their previous values and `wb_valid` is 0.
- R3: ADD (code 0) and SUB (code 2) update all six bits, as follows. Carry is the carry out of bit 7, or the borrow for subtraction. Half-carry is the carry or borrow out of bit 3. Sign is bit 7 of the result. Zero is set when the result is 0. Parity is set when the result holds an even number of ones. Overflow is set on two's-complement overflow.
- R4: ADC (code 1) adds `flags_in` carry to the sum. SBB (code 3) subtracts it as well. Both update all six bits as in R3.
- R5: INC (code 4) and DEC (code 5) add or subtract 1 and update the five non-carry bits as in R3. They copy carry from `flags_in`.
- R6: CMP (code 6) sets the condition word exactly as SUB would. It raises no `wb_valid` and leaves `result` unchanged.
- R7: AND (code 7), OR (code 8) and XOR (code 9) write the bitwise result. They clear carry, overflow and half-carry, and set sign, zero and parity from the result.
- R8: TEST (code 10) sets the condition word as AND would. It raises no `wb_valid` and leaves `result` unchanged.
- R9: NOT (code 11) writes the one's complement of `a` and copies `flags_in` to `flags_out` unchanged.
- R10: NEG (code 12) writes 0 minus `a` and sets all six bits as a subtraction from zero would. Carry is therefore set exactly when `a` is nonzero.
- R11: Codes 13 to 15 raise no `wb_valid`, leave `result` unchanged and copy `flags_in` to `flags_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation request for this cycle |
| opcode | input | 4 | Operation code (see requirements) |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| flags_in | input | 6 | Current condition word |
| result | output | 8 | Last written result |
| wb_valid | output | 1 | Writeback strobe, one cycle |
| flags_out | output | 6 | Updated condition word |

## Verification
Each of this block's results is due exactly one rising edge after the cycle in which `issue` is seen. This applies to the result, the writeback strobe and the condition word alike. The bench drives an operation on a falling edge, lets one rising edge pass, removes `issue` and samples all three outputs on the next falling edge. It then waits one more falling edge to confirm that the strobe has dropped and the registered values hold. Expected values come from integer arithmetic in the bench, with the half-carry taken from the low nibbles and the overflow taken from a signed range test.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int FLAG_W = 6;
    localparam int FB_C   = 0;
    localparam int FB_P   = 1;
    localparam int FB_A   = 2;
    localparam int FB_Z   = 3;
    localparam int FB_S   = 4;
    localparam int FB_O   = 5;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_INC = 4'd4,
        OP_DEC = 4'd5,
        OP_CMP = 4'd6,
        OP_AND = 4'd7,
        OP_OR  = 4'd8,
        OP_XOR = 4'd9,
        OP_TST = 4'd10,
        OP_NOT = 4'd11,
        OP_NEG = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        FM_FULL,
        FM_KEEPC,
        FM_LOGIC,
        FM_HOLD
    } flag_mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WRITE,
        S_PROBE
    } alu_state_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_NOT
    } logic_sel_e;

endpackage

// File: rtl/flag_arith.sv
module flag_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         a_out,
    output logic         o_out
);
    localparam int HB = 4;

    logic [W:0] ext;

    always_comb begin
        if (sub)
            ext = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
        else
            ext = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    end

    assign res   = ext[W-1:0];
    assign c_out = ext[W];
    assign a_out = x[HB] ^ y[HB] ^ ext[HB];

    always_comb begin
        if (sub)
            o_out = (x[W-1] != y[W-1]) && (ext[W-1] != x[W-1]);
        else
            o_out = (x[W-1] == y[W-1]) && (ext[W-1] != x[W-1]);
    end
endmodule

// File: rtl/flag_logic.sv
module flag_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic_sel_e   sel,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (sel)
            LG_AND:  res = x & y;
            LG_OR:   res = x | y;
            LG_XOR:  res = x ^ y;
            LG_NOT:  res = ~x;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/flag_status.sv
module flag_status #(
    parameter int W = 8
) (
    input  logic [W-1:0] res,
    output logic         s,
    output logic         z,
    output logic         p
);
    localparam int PW = (W < 8) ? W : 8;

    assign s = res[W-1];
    assign z = (res == '0);
    assign p = ~^res[PW-1:0];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue,
    input  logic [3:0]          opcode,
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    input  logic [FLAG_W-1:0]   flags_in,
    output logic [W-1:0]        result,
    output logic                wb_valid,
    output logic [FLAG_W-1:0]   flags_out
);
    localparam logic [W-1:0] ONE = W'(1);

    // decode
    logic [W-1:0] ar_x, ar_y;
    logic         ar_cin, ar_sub, use_logic, writes, probe;
    logic_sel_e   lg_sel;
    flag_mode_e   fmode;

    always_comb begin
        ar_x      = a;
        ar_y      = b;
        ar_cin    = 1'b0;
        ar_sub    = 1'b0;
        use_logic = 1'b0;
        lg_sel    = LG_AND;
        writes    = 1'b1;
        probe     = 1'b0;
        fmode     = FM_FULL;
        case (alu_op_e'(opcode))
            OP_ADD: ;
            OP_ADC: ar_cin = flags_in[FB_C];
            OP_SUB: ar_sub = 1'b1;
            OP_SBB: begin ar_sub = 1'b1; ar_cin = flags_in[FB_C]; end
            OP_INC: begin ar_y = ONE; fmode = FM_KEEPC; end
            OP_DEC: begin ar_y = ONE; ar_sub = 1'b1; fmode = FM_KEEPC; end
            OP_CMP: begin ar_sub = 1'b1; writes = 1'b0; probe = 1'b1; end
            OP_AND: begin use_logic = 1'b1; lg_sel = LG_AND; fmode = FM_LOGIC; end
            OP_OR:  begin use_logic = 1'b1; lg_sel = LG_OR;  fmode = FM_LOGIC; end
            OP_XOR: begin use_logic = 1'b1; lg_sel = LG_XOR; fmode = FM_LOGIC; end
            OP_TST: begin
                use_logic = 1'b1; lg_sel = LG_AND; fmode = FM_LOGIC;
                writes = 1'b0; probe = 1'b1;
            end
            OP_NOT: begin use_logic = 1'b1; lg_sel = LG_NOT; fmode = FM_HOLD; end
            OP_NEG: begin ar_x = '0; ar_y = a; ar_sub = 1'b1; end
            default: begin writes = 1'b0; fmode = FM_HOLD; end
        endcase
    end

    // datapath
    logic [W-1:0] ar_res, lg_res, sel_res;
    logic         ar_c, ar_a, ar_o, st_s, st_z, st_p;

    flag_arith #(.W(W)) u_arith (
        .x(ar_x), .y(ar_y), .cin(ar_cin), .sub(ar_sub),
        .res(ar_res), .c_out(ar_c), .a_out(ar_a), .o_out(ar_o)
    );

    flag_logic #(.W(W)) u_logic (
        .x(a), .y(b), .sel(lg_sel), .res(lg_res)
    );

    assign sel_res = use_logic ? lg_res : ar_res;

    flag_status #(.W(W)) u_status (
        .res(sel_res), .s(st_s), .z(st_z), .p(st_p)
    );

    logic [FLAG_W-1:0] flags_nx;

    always_comb begin
        flags_nx = flags_in;
        unique case (fmode)
            FM_FULL, FM_KEEPC: begin
                flags_nx[FB_C] = (fmode == FM_FULL) ? ar_c : flags_in[FB_C];
                flags_nx[FB_A] = ar_a;
                flags_nx[FB_O] = ar_o;
                flags_nx[FB_S] = st_s;
                flags_nx[FB_Z] = st_z;
                flags_nx[FB_P] = st_p;
            end
            FM_LOGIC: begin
                flags_nx[FB_C] = 1'b0;
                flags_nx[FB_A] = 1'b0;
                flags_nx[FB_O] = 1'b0;
                flags_nx[FB_S] = st_s;
                flags_nx[FB_Z] = st_z;
                flags_nx[FB_P] = st_p;
            end
            default: flags_nx = flags_in;
        endcase
    end

    // controller: state register
    alu_state_e state_q, state_d;

    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE, S_WRITE, S_PROBE: begin
                if (issue && writes)     state_d = S_WRITE;
                else if (issue && probe) state_d = S_PROBE;
                else                     state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // controller: outputs
    logic [W-1:0]      res_q;
    logic [FLAG_W-1:0] flg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (issue) begin
            if (writes) res_q <= sel_res;
            flg_q <= flags_nx;
        end
    end

    assign result    = res_q;
    assign flags_out = flg_q;
    assign wb_valid  = (state_q == S_WRITE);

    // assertions
    assert_wb_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(issue));

    assert_zero_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (opcode inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7, 4'd8, 4'd9, 4'd12}))
        |=> (flags_out[FB_Z] == (result == '0)));

    assert_inc_dec_keep_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (opcode == 4'd4 || opcode == 4'd5))
        |=> flags_out[FB_C] == $past(flags_in[FB_C]));

    assert_probe_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (opcode == 4'd6 || opcode == 4'd10)) |=> (!wb_valid && $stable(result)));

    assert_logic_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (opcode inside {4'd7, 4'd8, 4'd9, 4'd10}))
        |=> (!flags_out[FB_C] && !flags_out[FB_O] && !flags_out[FB_A]));

    assert_not_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode == 4'd11) |=> flags_out == $past(flags_in));

    assert_neg_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode == 4'd12) |=> flags_out[FB_C] == ($past(a) != '0));

    assert_unused_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode >= 4'd13) |=> (!wb_valid && flags_out == $past(flags_in)));
endmodule

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [3:0] opcode = '0;
    logic [7:0] a = '0, b = '0;
    logic [5:0] flags_in = '0;
    logic [7:0] result;
    logic       wb_valid;
    logic [5:0] flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] last_res = '0;
    logic [5:0] last_flg = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .a(a), .b(b), .flags_in(flags_in),
        .result(result), .wb_valid(wb_valid), .flags_out(flags_out)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // model: returns {wb, flags[5:0], result[7:0]}
    function automatic logic [14:0] model(input int op, input int x, input int y, input logic [5:0] fi);
        int r, ci, sx, sy, sr, lo;
        logic [5:0] f;
        logic [7:0] res;
        logic wb, upd;
        f = fi; wb = 1'b1; upd = 1'b1; res = 8'h00; ci = 0;
        sx = (x > 127) ? x - 256 : x;
        sy = (y > 127) ? y - 256 : y;
        case (op)
            0, 1, 4: begin
                ci = (op == 1) ? int'(fi[0]) : 0;
                if (op == 4) begin y = 1; sy = 1; end
                r = x + y + ci; res = r[7:0];
                if (op != 4) f[0] = (r > 255);
                lo = (x % 16) + (y % 16) + ci; f[2] = (lo > 15);
                sr = sx + sy + ci; f[5] = (sr > 127) || (sr < -128);
            end
            2, 3, 5, 6, 12: begin
                ci = (op == 3) ? int'(fi[0]) : 0;
                if (op == 5) begin y = 1; sy = 1; end
                if (op == 12) begin y = x; sy = sx; x = 0; sx = 0; end
                r = x - y - ci; res = r[7:0];
                if (op != 5) f[0] = (r < 0);
                lo = (x % 16) - (y % 16) - ci; f[2] = (lo < 0);
                sr = sx - sy - ci; f[5] = (sr > 127) || (sr < -128);
                wb = (op != 6);
            end
            7, 8, 9, 10: begin
                if (op == 8) res = 8'(x | y);
                else if (op == 9) res = 8'(x ^ y);
                else res = 8'(x & y);
                f[0] = 0; f[2] = 0; f[5] = 0;
                wb = (op != 10);
            end
            11: begin res = ~8'(x); upd = 0; end
            default: begin wb = 0; upd = 0; end
        endcase
        if (upd) begin
            f[4] = res[7];
            f[3] = (res == 8'h00);
            f[1] = ($countones(res) % 2 == 0);
        end
        return {wb, f, res};
    endfunction

    task automatic run_op(input string tag, input int op, input int x, input int y, input logic [5:0] fi);
        logic [14:0] m;
        logic [7:0] er;
        m = model(op, x, y, fi);
        @(negedge clk);
        issue = 1'b1; opcode = 4'(op); a = 8'(x); b = 8'(y); flags_in = fi;
        @(negedge clk);
        issue = 1'b0;
        er = m[14] ? m[7:0] : last_res;
        chk(tag, "result", int'(result), int'(er));
        chk(tag, "wb_valid", int'(wb_valid), int'(m[14]));
        chk(tag, "flags", int'(flags_out), int'(m[13:8]));
        last_res = er;
        last_flg = m[13:8];
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset result", int'(result), 0);
        chk("R1", "reset wb", int'(wb_valid), 0);
        chk("R1", "reset flags", int'(flags_out), 0);
        rst_n = 1'b1;
        last_res = '0;
    endtask

    task automatic t_timing;
        run_op("R2", 0, 8'h12, 8'h34, 6'h00);
        a = 8'hFF; b = 8'hFF; flags_in = 6'h3F; opcode = 4'd2;
        @(negedge clk);
        chk("R2", "strobe drops", int'(wb_valid), 0);
        chk("R2", "result holds", int'(result), int'(last_res));
        chk("R2", "flags hold", int'(flags_out), int'(last_flg));
        run_op("R2", 0, 1, 1, 6'h00);
        run_op("R2", 0, 2, 3, 6'h00);
    endtask

    task automatic t_addsub;
        run_op("R3", 0, 8'h7F, 8'h01, 6'h00);
        run_op("R3", 0, 8'hFF, 8'h01, 6'h00);
        run_op("R3", 2, 8'h00, 8'h01, 6'h00);
        run_op("R3", 2, 8'h80, 8'h01, 6'h3F);
        run_op("R3", 2, 8'h55, 8'h55, 6'h00);
    endtask

    task automatic t_carry_in;
        run_op("R4", 1, 8'hFF, 8'h00, 6'h01);
        run_op("R4", 1, 8'h10, 8'h20, 6'h00);
        run_op("R4", 3, 8'h05, 8'h05, 6'h01);
        run_op("R4", 3, 8'h05, 8'h03, 6'h01);
    endtask

    task automatic t_incdec;
        run_op("R5", 4, 8'hFF, 8'h00, 6'h00);
        run_op("R5", 4, 8'h0F, 8'h00, 6'h01);
        run_op("R5", 5, 8'h00, 8'h00, 6'h01);
        run_op("R5", 5, 8'h80, 8'h00, 6'h00);
    endtask

    task automatic t_compare;
        run_op("R6", 0, 8'hA5, 8'h00, 6'h00);
        run_op("R6", 6, 8'h03, 8'h05, 6'h00);
        run_op("R6", 6, 8'h40, 8'h40, 6'h3F);
    endtask

    task automatic t_logic;
        run_op("R7", 7, 8'hF0, 8'h3C, 6'h3F);
        run_op("R7", 8, 8'h00, 8'h00, 6'h3F);
        run_op("R7", 9, 8'hAA, 8'h0F, 6'h25);
    endtask

    task automatic t_test;
        run_op("R8", 0, 8'h11, 8'h22, 6'h00);
        run_op("R8", 10, 8'hF0, 8'h0F, 6'h3F);
        run_op("R8", 10, 8'h81, 8'h80, 6'h00);
    endtask

    task automatic t_not;
        run_op("R9", 11, 8'h5A, 8'h00, 6'h2A);
        run_op("R9", 11, 8'hFF, 8'h00, 6'h15);
    endtask

    task automatic t_neg;
        run_op("R10", 12, 8'h00, 8'h00, 6'h3F);
        run_op("R10", 12, 8'h80, 8'h00, 6'h00);
        run_op("R10", 12, 8'h01, 8'h00, 6'h00);
    endtask

    task automatic t_unused;
        run_op("R11", 0, 8'h21, 8'h21, 6'h00);
        run_op("R11", 13, 8'h01, 8'h02, 6'h15);
        run_op("R11", 15, 8'hFF, 8'hFF, 6'h2A);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_addsub();
        t_carry_in();
        t_incdec();
        t_compare();
        t_logic();
        t_test();
        t_not();
        t_neg();
        t_unused();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule